// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Controller

This block is the device-side control for one receive channel. The channel fills host buffers named by a ring of buffer descriptors. The ring size is a power of two. Software writes a configuration word and a write index that points one past the last descriptor it has made available. The block takes incoming data beats into the buffer of the current descriptor. When a buffer is closed, the block posts the index of that descriptor through a status-write request. The bus behind that request is external and answers with an acknowledge.

A buffer closes in one of three ways: the frame ends, the buffer reaches its capacity, or the line stays quiet past a programmable timeout while the buffer holds data. A close caused by the end of a frame or by the timeout can raise an interrupt. The channel has three modes: off, stop after the current frame, and run. An idle output tells software when the channel has fully stopped. The host memory bus and the frame data path are out of scope. Each is reduced to a valid/ready beat port and a request/acknowledge status port.

Top module: `rx_ring_dma`

## Requirements
- R1: The configuration word is decoded as follows. Bits 31:30 hold the mode: 10 = run, 01 = stop after the current frame, 00 or 11 = off. Bits 23:20 hold log2 of the ring size, clamped to the range 5..12. Bits 17:16 hold the buffer-size code. Bits 13:12 = 01 enables the interrupt. Bits 11:4 hold the timeout in ticks. The other bits have no effect.
- R2: A write-index update whose low three bits are zero is taken, masked to the ring size. Any other update is ignored and sets `widx_err`, which stays set until reset.
- R3: A beat is accepted only while the current descriptor `cur_desc` differs from the write index. So the ring holds at most size-1 filled buffers, and both indexes wrap at the ring size.
- R4: A beat with `beat_last` set closes the buffer. A close caused by the frame end or by the timeout pulses `irq` for one cycle, aligned with the rise of `st_req`, only when the interrupt is enabled.
- R5: A buffer also closes when it reaches (size code + 1) × BEATS_4K beats, and that close does not raise `irq`.
- R6: A partly filled buffer closes once timeout × PRESCALE clock cycles pass with no accepted beat. Each accepted beat restarts the count. A timeout of 0 disables this close.
- R7: On a close, `st_req` rises with `st_idx` set to the index of the filled descriptor. Both hold until `st_ack`. `cur_desc` advances by one, modulo the ring size. No beat is accepted while `st_req` is high.
- R8: In run mode, beats are accepted. In stop-after-frame mode, beats are accepted only until the end of the frame in progress. In off mode, no beat is accepted and the frame in progress is abandoned.
- R9: `idle` is high when the mode is not run, no frame is in progress and no status write is pending.
- R10: After reset, the mode is off, `cur_desc` and the write index are 0, and `beat_ready`, `st_req`, `irq` and `widx_err` are low, with `idle` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word |
| widx_we | input | 1 | Write-index update strobe |
| widx_wdata | input | IDX_W | New write index |
| widx_err | output | 1 | Sticky flag: a misaligned write index was rejected |
| beat_valid | input | 1 | Receive data beat present |
| beat_last | input | 1 | Beat ends the frame |
| beat_ready | output | 1 | Beat is taken this cycle |
| cur_desc | output | IDX_W | Descriptor currently being filled |
| st_req | output | 1 | Status write request |
| st_idx | output | IDX_W | Index of the last filled descriptor |
| st_ack | input | 1 | Status write done |
| irq | output | 1 | One-cycle interrupt pulse |
| idle | output | 1 | Channel fully stopped |

## Verification
Some properties are checked on every cycle. The checker confirms that no beat is accepted when the current descriptor equals the write index, and none while a status write is pending. It confirms that the request and its index hold until acknowledge, that the descriptor index steps by one at each close, that an interrupt comes only with a new request, that off mode never accepts a beat, and that idle never coincides with activity. Other behaviour can only be seen through the bench's scenarios. Those cover the exact cycle of a timeout close and its restart, the per-cause interrupt rule, the capacity for a given size code, rejection of a misaligned write index, wrap at the ring end, and the stop-after-frame sequence.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_DRAIN = 2'b01,
    MODE_RUN   = 2'b10,
    MODE_RSVD  = 2'b11
  } rx_mode_e;

  typedef struct packed {
    rx_mode_e   mode;
    logic       irq_host;
    logic [7:0] tmo;
  } rx_cfg_t;

endpackage

// File: rtl/rx_cfg_decode.sv
module rx_cfg_decode
  import rx_ring_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int BEATS_4K = 4,
  parameter int CNT_W    = 5
) (
  input  logic [31:0]      word,
  output rx_cfg_t          cfg,
  output logic [IDX_W-1:0] ring_mask,
  output logic [CNT_W-1:0] cap
);
  localparam int MIN_LOG2 = 5;
  localparam int MAX_LOG2 = IDX_W;
  localparam logic [IDX_W-1:0] ONE_IDX = {{(IDX_W-1){1'b0}}, 1'b1};

  logic [3:0]     n_raw;
  logic [3:0]     n_cl;
  logic [IDX_W:0] pow;
  logic           unused_bits;

  assign unused_bits = ^{word[29:24], word[19:18], word[15:14], word[3:0]};

  always_comb begin
    n_raw = word[23:20];
    if (n_raw < 4'(MIN_LOG2))      n_cl = 4'(MIN_LOG2);
    else if (n_raw > 4'(MAX_LOG2)) n_cl = 4'(MAX_LOG2);
    else                           n_cl = n_raw;
    pow       = {{IDX_W{1'b0}}, 1'b1} << n_cl;
    ring_mask = pow[IDX_W-1:0] - ONE_IDX;
  end

  assign cap = CNT_W'(word[17:16]) * CNT_W'(BEATS_4K) + CNT_W'(BEATS_4K);

  assign cfg.mode     = rx_mode_e'(word[31:30]);
  assign cfg.irq_host = (word[13:12] == 2'b01);
  assign cfg.tmo      = word[11:4];

endmodule

// File: rtl/rx_ring_idx.sv
module rx_ring_idx #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             widx_we,
  input  logic [IDX_W-1:0] widx_wdata,
  input  logic [IDX_W-1:0] ring_mask,
  input  logic             adv,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] wr_idx,
  output logic             has_room,
  output logic             err
);
  localparam logic [IDX_W-1:0] ONE_IDX = {{(IDX_W-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] rd_q, rd_n, wr_q, wr_n;
  logic             err_q, err_n;
  logic             aligned;

  assign aligned = (widx_wdata[2:0] == 3'b000);

  always_comb begin
    rd_n  = adv ? ((rd_q + ONE_IDX) & ring_mask) : rd_q;
    wr_n  = wr_q;
    err_n = err_q;
    if (widx_we) begin
      if (aligned) wr_n  = widx_wdata & ring_mask;
      else         err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      err_q <= 1'b0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      err_q <= err_n;
    end
  end

  assign rd_idx   = rd_q & ring_mask;
  assign wr_idx   = wr_q & ring_mask;
  assign has_room = (rd_idx != wr_idx);
  assign err      = err_q;

endmodule

// File: rtl/rx_close_timer.sv
module rx_close_timer #(
  parameter int PRESCALE = 3200,
  parameter int TMO_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             armed,
  input  logic [TMO_W-1:0] tmo,
  output logic             expire
);
  localparam int PRE_W = $clog2(PRESCALE + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q, pre_n;
  logic [TMO_W-1:0] tick_q, tick_n;
  logic             tick;

  assign tick = (pre_q == PRE_LAST);

  always_comb begin
    pre_n  = pre_q;
    tick_n = tick_q;
    if (restart || !armed) begin
      pre_n  = '0;
      tick_n = '0;
    end else if (tick) begin
      pre_n  = '0;
      if (tick_q != '1) tick_n = tick_q + 1'b1;
    end else begin
      pre_n  = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else begin
      pre_q  <= pre_n;
      tick_q <= tick_n;
    end
  end

  assign expire = armed && !restart && (tmo != '0) && (tick_q >= tmo);

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rx_ring_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int BEATS_4K = 4,
  parameter int PRESCALE = 3200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic             widx_we,
  input  logic [IDX_W-1:0] widx_wdata,
  output logic             widx_err,
  input  logic             beat_valid,
  input  logic             beat_last,
  output logic             beat_ready,
  output logic [IDX_W-1:0] cur_desc,
  output logic             st_req,
  output logic [IDX_W-1:0] st_idx,
  input  logic             st_ack,
  output logic             irq,
  output logic             idle
);
  localparam int CNT_W = $clog2(4 * BEATS_4K + 1);

  logic [31:0]      cfg_q, cfg_n;
  logic [CNT_W-1:0] beats_q, beats_n;
  logic             in_frame_q, in_frame_n;
  logic             st_pend_q, st_pend_n;
  logic [IDX_W-1:0] st_idx_q, st_idx_n;
  logic             irq_q, irq_n;

  rx_cfg_t          cfg;
  logic [IDX_W-1:0] ring_mask, rd_idx, wr_idx;
  logic [CNT_W-1:0] cap;
  logic             has_room, allow, acc, at_cap, close, expire, armed, new_off;

  rx_cfg_decode #(.IDX_W(IDX_W), .BEATS_4K(BEATS_4K), .CNT_W(CNT_W)) u_dec (
    .word(cfg_q), .cfg(cfg), .ring_mask(ring_mask), .cap(cap)
  );

  rx_ring_idx #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .widx_we(widx_we), .widx_wdata(widx_wdata),
    .ring_mask(ring_mask), .adv(close), .rd_idx(rd_idx), .wr_idx(wr_idx),
    .has_room(has_room), .err(widx_err)
  );

  rx_close_timer #(.PRESCALE(PRESCALE), .TMO_W(8)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(acc), .armed(armed),
    .tmo(cfg.tmo), .expire(expire)
  );

  // Drain mode may only finish a frame already in progress.
  assign allow = (cfg.mode == MODE_RUN) || ((cfg.mode == MODE_DRAIN) && in_frame_q);
  assign beat_ready = allow && has_room && !st_pend_q;
  assign acc    = beat_valid && beat_ready;
  assign at_cap = (beats_q + 1'b1) == cap;
  assign armed  = (beats_q != '0) && !st_pend_q;
  assign close  = (acc && (beat_last || at_cap)) || expire;
  assign new_off = cfg_we && (cfg_wdata[31:30] != MODE_RUN) && (cfg_wdata[31:30] != MODE_DRAIN);

  always_comb begin
    cfg_n      = cfg_we ? cfg_wdata : cfg_q;
    beats_n    = close ? '0 : (acc ? beats_q + 1'b1 : beats_q);
    in_frame_n = in_frame_q;
    if (acc) in_frame_n = !beat_last;
    if (new_off) in_frame_n = 1'b0;
    st_pend_n  = close ? 1'b1 : (st_ack ? 1'b0 : st_pend_q);
    st_idx_n   = close ? rd_idx : st_idx_q;
    irq_n      = close && cfg.irq_host && ((acc && beat_last) || expire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      beats_q    <= '0;
      in_frame_q <= 1'b0;
      st_pend_q  <= 1'b0;
      st_idx_q   <= '0;
      irq_q      <= 1'b0;
    end else begin
      cfg_q      <= cfg_n;
      beats_q    <= beats_n;
      in_frame_q <= in_frame_n;
      st_pend_q  <= st_pend_n;
      st_idx_q   <= st_idx_n;
      irq_q      <= irq_n;
    end
  end

  assign cur_desc = rd_idx;
  assign st_req   = st_pend_q;
  assign st_idx   = st_idx_q;
  assign irq      = irq_q;
  assign idle     = (cfg.mode != MODE_RUN) && !in_frame_q && !st_pend_q;

endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic [IDX_W-1:0] cur_desc,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] ring_mask,
  input logic             st_req,
  input logic             st_ack,
  input logic [IDX_W-1:0] st_idx,
  input logic             irq,
  input logic             idle,
  input logic [1:0]       mode_bits
);
  localparam logic [IDX_W-1:0] ONE_IDX = {{(IDX_W-1){1'b0}}, 1'b1};

  a_r3_no_fill_full: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready) |-> (cur_desc != wr_idx));

  a_r7_hold_status: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !st_ack) |=> (st_req && $stable(st_idx)));

  a_r7_no_accept_pend: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> !beat_ready);

  a_r7_index_advance: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_req) |-> (cur_desc == ((st_idx + ONE_IDX) & ring_mask)));

  a_r4_irq_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $rose(st_req));

  a_r8_off_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 2'b00 || mode_bits == 2'b11) |-> !beat_ready);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!beat_ready && !st_req));

endmodule

bind rx_ring_dma rx_ring_dma_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .cur_desc(cur_desc), .wr_idx(wr_idx), .ring_mask(ring_mask),
  .st_req(st_req), .st_ack(st_ack), .st_idx(st_idx), .irq(irq),
  .idle(idle), .mode_bits(cfg_q[31:30])
);

// File: tb/tb_rx_ring_dma.sv
module tb_rx_ring_dma;
  localparam int IDX_W = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we = 1'b0;
  logic [31:0]      cfg_wdata = '0;
  logic             widx_we = 1'b0;
  logic [IDX_W-1:0] widx_wdata = '0;
  logic             widx_err;
  logic             beat_valid = 1'b0;
  logic             beat_last = 1'b0;
  logic             beat_ready;
  logic [IDX_W-1:0] cur_desc;
  logic             st_req;
  logic [IDX_W-1:0] st_idx;
  logic             st_ack = 1'b0;
  logic             irq;
  logic             idle;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rx_ring_dma #(.IDX_W(IDX_W), .BEATS_4K(4), .PRESCALE(4)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .widx_we(widx_we), .widx_wdata(widx_wdata), .widx_err(widx_err),
    .beat_valid(beat_valid), .beat_last(beat_last), .beat_ready(beat_ready),
    .cur_desc(cur_desc), .st_req(st_req), .st_idx(st_idx), .st_ack(st_ack),
    .irq(irq), .idle(idle)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {write index, expected sticky error after the write}
  localparam logic [12:0] WTAB [5] = '{
    {12'd0, 1'b0}, {12'd8, 1'b0}, {12'd24, 1'b0}, {12'd13, 1'b1}, {12'd16, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_widx(input int w);
    @(negedge clk); widx_we = 1'b1; widx_wdata = IDX_W'(w);
    @(negedge clk); widx_we = 1'b0;
  endtask

  task automatic beat(input bit last);
    int g = 0;
    while (!beat_ready && g < 1000) begin @(negedge clk); g++; end
    beat_valid = 1'b1; beat_last = last;
    @(negedge clk);
    beat_valid = 1'b0; beat_last = 1'b0;
  endtask

  task automatic ack(output int idx);
    int g = 0;
    while (!st_req && g < 1000) begin @(negedge clk); g++; end
    idx = int'(st_idx);
    st_ack = 1'b1;
    @(negedge clk);
    st_ack = 1'b0;
  endtask

  initial begin
    int idx, irq0, bad;
    rst_n = 1'b0;
    wait_n(3);
    // R10 reset state
    chk(!beat_ready, "R10 ready", beat_ready, 0);
    chk(!st_req && !irq, "R10 req/irq", st_req, 0);
    chk(idle, "R10 idle", idle, 1);
    chk(!widx_err && cur_desc == 0, "R10 err/desc", int'(cur_desc), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 write-index table
    for (int i = 0; i < 5; i++) begin
      set_widx(int'(WTAB[i][12:1]));
      chk(widx_err == WTAB[i][0], "R2 widx_err", widx_err, int'(WTAB[i][0]));
    end

    // R1/R8 run, ring 32, size code 0, interrupt on, no timeout
    set_cfg(32'h8050_1000);
    chk(beat_ready && !idle, "R8 run ready / R9 not idle", beat_ready, 1);
    beat(0); beat(1);
    chk(st_req && !beat_ready, "R7 pend blocks beats", beat_ready, 0);
    ack(idx);
    chk(idx == 0 && irq_cnt == 1, "R4 eof close irq", irq_cnt, 1);
    chk(cur_desc == 1, "R7 desc advance", int'(cur_desc), 1);

    // R5 capacity close, no interrupt
    for (int i = 0; i < 4; i++) beat(0);
    ack(idx);
    chk(idx == 1 && irq_cnt == 1, "R5 full close no irq", irq_cnt, 1);
    beat(0); beat(1);
    ack(idx);
    chk(idx == 2 && irq_cnt == 2, "R4 frame end after spill", idx, 2);

    // R3 fill up to write index 16 (13 was ignored)
    bad = 0;
    for (int i = 3; i < 16; i++) begin beat(1); ack(idx); if (idx != i) bad++; end
    chk(bad == 0, "R7 status index run", bad, 0);
    chk(!beat_ready && cur_desc == 16, "R3 stall at write index", int'(cur_desc), 16);
    set_widx(4);
    chk(!beat_ready && widx_err, "R2 misaligned ignored", beat_ready, 0);
    set_widx(0);
    chk(beat_ready, "R3 room after update", beat_ready, 1);
    for (int i = 16; i < 32; i++) begin beat(1); ack(idx); end
    chk(idx == 31, "R7 last index before wrap", idx, 31);
    chk(!beat_ready && cur_desc == 0, "R3 wrap holds size-1", int'(cur_desc), 0);
    set_widx(8);
    beat(1); ack(idx);
    chk(idx == 0 && cur_desc == 1, "R3 wrap fill index 0", idx, 0);

    // R6 timeout of 2 ticks, prescale 4
    set_cfg(32'h8050_1020);
    irq0 = irq_cnt;
    beat(0);
    wait_n(8);
    chk(!st_req, "R6 no early close", st_req, 0);
    wait_n(2);
    chk(st_req, "R6 timeout close", st_req, 1);
    ack(idx);
    chk(idx == 1 && irq_cnt == irq0 + 1, "R6 timeout irq", irq_cnt, irq0 + 1);
    beat(0);
    wait_n(5);
    beat(0);
    wait_n(8);
    chk(!st_req, "R6 beat restarts count", st_req, 0);
    wait_n(2);
    chk(st_req, "R6 close after restart", st_req, 1);
    ack(idx);

    // R8/R9 stop after the frame in progress
    set_cfg(32'h4050_1000);
    chk(beat_ready && !idle, "R8 drain finishes frame", beat_ready, 1);
    beat(1);
    chk(st_req && !idle, "R9 not idle while pending", idle, 0);
    ack(idx);
    chk(idx == 3, "R7 drain index", idx, 3);
    chk(idle && !beat_ready, "R9 idle after drain", idle, 1);

    // R5/R4 size code 1, interrupt off
    set_cfg(32'h8051_0000);
    irq0 = irq_cnt;
    for (int i = 0; i < 7; i++) beat(0);
    chk(!st_req, "R5 size code 1 not full at 7", st_req, 0);
    beat(0);
    chk(st_req, "R5 size code 1 full at 8", st_req, 1);
    ack(idx);
    beat(1); ack(idx);
    chk(irq_cnt == irq0, "R4 interrupt disabled", irq_cnt, irq0);

    // R8 off abandons frame
    beat(0);
    set_cfg(32'h0000_0000);
    chk(!beat_ready && idle, "R8 off / R9 idle", idle, 1);

    // R10 / R2 sticky until reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(!widx_err && cur_desc == 0 && idle, "R10 second reset", widx_err, 0);
    rst_n = 1'b1;
    wait_n(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule